// File: doc/BRIEF.md
# Two-Location Sequential-Probe Cache

This block is a single-ported line store that gives most of the conflict tolerance of a two-way cache while comparing only one stored tag per cycle. Every address has a home slot, given by its low index bits, and an alternate slot, which is the home slot with the top index bit inverted. A lookup compares the home slot first. Only when that comparison fails does the block compare the alternate slot, one cycle later. A home-slot hit therefore costs the same as a plain direct-mapped lookup, and only conflicting addresses pay for the extra compare.

Each line holds a valid bit, a dirty bit, a tag, a data word and a placement flag. The flag records whether the line sits in the home slot of its address or in the alternate slot. A tag match counts only when the flag agrees with the slot being compared, so two addresses whose tags are equal and whose home slots differ only in the top index bit can never be confused. When an access hits in the alternate slot, the two slots trade contents, and the flags are updated. The next access to that address then hits in the home slot.

A core issues requests through a valid/busy handshake and gets a single-cycle hit or miss pulse with read data and the line's dirty state. A separate fill port places a line into the home or alternate slot. Fetching the fill data and writing back evicted lines happen outside this block.

Top module: `hrc_cache`

## Requirements
- R1: After reset, busy, resp_hit and resp_miss are low and every line is invalid, so any request that follows reports a miss until a fill places the line.
- R2: A request is accepted at a rising edge where req_valid is high and busy is low. If the home slot (index = req_addr[IDX_W-1:0]) holds a valid line with the same tag (req_addr[ADDR_W-1:IDX_W]) and a home placement flag, resp_hit is high in the cycle after the next rising edge (latency 1), with that line's data on resp_rdata.
- R3: The alternate slot is the home index with its most significant bit inverted. A match there, with an alternate placement flag, raises resp_hit one cycle later than a home hit (latency 2).
- R4: When neither slot matches, resp_miss is raised with latency 2, and resp_rdata and resp_dirty are zero. A write miss allocates nothing, so a repeat of the same access misses again.
- R5: A line filled with fill_rehash = 0 matches only in the home comparison, and one filled with fill_rehash = 1 matches only in the alternate comparison, even when the stored tag equals the request tag.
- R6: A hit in the alternate slot swaps the contents of the two slots and inverts both placement flags. The same address then hits with latency 1, and the displaced line is still found, with latency 2.
- R7: A write hit stores req_wdata in the line and sets its dirty bit. Its response returns the written data with resp_dirty = 1, and later read hits report resp_dirty = 1 until a fill of that slot clears the dirty bit to 0.
- R8: busy is high from the cycle after acceptance through the response cycle. Requests presented while busy is high are ignored and produce no response.
- R9: resp_hit and resp_miss are never high together. Each lasts exactly one cycle per accepted request.
- R10: A fill is taken at a rising edge where fill_valid is high and busy is low. It writes fill_addr's tag and fill_data, marks the line valid and clean, and places it in the home slot (fill_rehash = 0) or the alternate slot (fill_rehash = 1). A fill offered while busy is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Data for a write request |
| busy | output | 1 | Lookup in progress, so new requests and fills are not taken |
| resp_hit | output | 1 | One-cycle pulse: the request hit |
| resp_miss | output | 1 | One-cycle pulse: the request missed |
| resp_rdata | output | DATA_W | Line data on a hit, zero on a miss |
| resp_dirty | output | 1 | Dirty bit of the hit line after the access |
| fill_valid | input | 1 | Fill line present |
| fill_rehash | input | 1 | 0 = place in home slot, 1 = place in alternate slot |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_data | input | DATA_W | Data of the filled line |

## Verification
The embedded properties assume that inputs are stable around each rising edge. They also assume that a fill and the swap or update of a lookup never target the store in the same cycle, which holds because the block takes fills only while idle. The stimulus changes inputs only on falling edges, raises req_valid only after it has seen busy low, and offers requests and fills during a busy window only on purpose, to show that they are dropped. Tag and index values are chosen so that lines which alias in the home or alternate slot, and tags that are equal but placed differently, each occur.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

   // lookup sequencer states
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROBE1 = 2'd1,
      ST_PROBE2 = 2'd2,
      ST_RESP   = 2'd3
   } probe_st_e;

endpackage

// File: rtl/hrc_way_cmp.sv
module hrc_way_cmp #(
   parameter int TAG_W = 12
) (
   input  logic             line_valid,
   input  logic             line_alt,
   input  logic [TAG_W-1:0] line_tag,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             want_alt,
   output logic             match
);

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("hrc_way_cmp: TAG_W must be at least 1");
      end
   endgenerate

   always_comb begin
      match = line_valid && (line_alt == want_alt) && (line_tag == req_tag);
   end

endmodule

// File: rtl/hrc_line_store.sv
module hrc_line_store #(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   // slot A (home) and slot B (alternate) read ports
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [IDX_W-1:0]  b_idx,
   output logic              a_valid,
   output logic              a_dirty,
   output logic              a_alt,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   output logic              b_valid,
   output logic              b_dirty,
   output logic              b_alt,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_data,
   // fill write
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic              fill_alt,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   // exchange slot A and slot B
   input  logic              swap_en,
   // write data into slot A and mark it dirty
   input  logic              upd_en,
   input  logic [DATA_W-1:0] upd_data
);

   localparam int LINES = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
         $error("hrc_line_store: IDX_W must lie in 1..10");
      end
   endgenerate

   logic [LINES-1:0]  vld_vec;
   logic [LINES-1:0]  drt_vec;
   logic [LINES-1:0]  alt_vec;
   logic [TAG_W-1:0]  tag_arr [LINES];
   logic [DATA_W-1:0] dat_arr [LINES];

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         localparam logic [IDX_W-1:0] ME = IDX_W'(i);
         logic              v_r;
         logic              d_r;
         logic              f_r;
         logic [TAG_W-1:0]  t_r;
         logic [DATA_W-1:0] x_r;

         always_ff @(posedge clk) begin
            if (rst) begin
               v_r <= 1'b0;
               d_r <= 1'b0;
               f_r <= 1'b0;
               t_r <= '0;
               x_r <= '0;
            end else if (fill_en && fill_idx == ME) begin
               v_r <= 1'b1;
               d_r <= 1'b0;
               f_r <= fill_alt;
               t_r <= fill_tag;
               x_r <= fill_data;
            end else begin
               if (swap_en && a_idx == ME) begin
                  v_r <= b_valid;
                  d_r <= b_dirty;
                  f_r <= ~b_alt;
                  t_r <= b_tag;
                  x_r <= b_data;
               end else if (swap_en && b_idx == ME) begin
                  v_r <= a_valid;
                  d_r <= a_dirty;
                  f_r <= ~a_alt;
                  t_r <= a_tag;
                  x_r <= a_data;
               end
               if (upd_en && a_idx == ME) begin
                  d_r <= 1'b1;
                  x_r <= upd_data;
               end
            end
         end

         assign vld_vec[i] = v_r;
         assign drt_vec[i] = d_r;
         assign alt_vec[i] = f_r;
         assign tag_arr[i] = t_r;
         assign dat_arr[i] = x_r;
      end
   endgenerate

   assign a_valid = vld_vec[a_idx];
   assign a_dirty = drt_vec[a_idx];
   assign a_alt   = alt_vec[a_idx];
   assign a_tag   = tag_arr[a_idx];
   assign a_data  = dat_arr[a_idx];
   assign b_valid = vld_vec[b_idx];
   assign b_dirty = drt_vec[b_idx];
   assign b_alt   = alt_vec[b_idx];
   assign b_tag   = tag_arr[b_idx];
   assign b_data  = dat_arr[b_idx];

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (vld_vec == '0));

   // R6
   swap_move_chk: assert property (@(posedge clk) disable iff (rst)
      swap_en |=> (tag_arr[$past(a_idx)] == $past(b_tag))
               && (alt_vec[$past(a_idx)] != $past(b_alt))
               && (tag_arr[$past(b_idx)] == $past(a_tag)));

   // R7
   write_dirty_chk: assert property (@(posedge clk) disable iff (rst)
      upd_en |=> drt_vec[$past(a_idx)]);

   // R10
   fill_place_chk: assert property (@(posedge clk) disable iff (rst)
      fill_en |=> vld_vec[$past(fill_idx)] && !drt_vec[$past(fill_idx)]);

endmodule

// File: rtl/hrc_probe_fsm.sv
module hrc_probe_fsm
   import hrc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start,
   input  logic      hit_home,
   output probe_st_e st
);

   probe_st_e st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (start) st_nx = ST_PROBE1;
         ST_PROBE1: st_nx = hit_home ? ST_RESP : ST_PROBE2;
         ST_PROBE2: st_nx = ST_RESP;
         ST_RESP:   st_nx = ST_IDLE;
         default:   st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ST_IDLE;
      else     st <= st_nx;
   end

   // R8
   probe_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PROBE1) |-> ($past(st) == ST_IDLE));

   // R2
   home_fast_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PROBE1 && hit_home) |=> (st == ST_RESP));

   // R3
   second_probe_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PROBE2) |=> (st == ST_RESP));

endmodule

// File: rtl/hrc_cache.sv
module hrc_cache
   import hrc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              resp_hit,
   output logic              resp_miss,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              resp_dirty,
   input  logic              fill_valid,
   input  logic              fill_rehash,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data
);

   localparam int TAG_W = ADDR_W - IDX_W;
   localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

   generate
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("hrc_cache: ADDR_W must exceed IDX_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("hrc_cache: DATA_W must be at least 1");
      end
   endgenerate

   probe_st_e st;

   logic              accept;
   logic              fill_en;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [IDX_W-1:0]  home_idx;
   logic [IDX_W-1:0]  alt_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  fill_home;
   logic [IDX_W-1:0]  fill_idx;

   logic              a_valid, a_dirty, a_alt;
   logic [TAG_W-1:0]  a_tag;
   logic [DATA_W-1:0] a_data;
   logic              b_valid, b_dirty, b_alt;
   logic [TAG_W-1:0]  b_tag;
   logic [DATA_W-1:0] b_data;
   logic              hit_home;
   logic              hit_alt;
   logic              swap_en;
   logic              upd_en;

   logic              res_hit_q;
   logic              res_dirty_q;
   logic [DATA_W-1:0] res_data_q;

   assign busy    = (st != ST_IDLE);
   assign accept  = req_valid && !busy;
   assign fill_en = fill_valid && !busy;

   // capture the request on acceptance
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         we_q    <= req_we;
         wdata_q <= req_wdata;
      end
   end

   assign home_idx  = addr_q[IDX_W-1:0];
   assign alt_idx   = home_idx ^ FLIP;
   assign req_tag   = addr_q[ADDR_W-1:IDX_W];
   assign fill_home = fill_addr[IDX_W-1:0];
   assign fill_idx  = fill_rehash ? (fill_home ^ FLIP) : fill_home;

   hrc_line_store #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .a_idx     (home_idx),
      .b_idx     (alt_idx),
      .a_valid   (a_valid),
      .a_dirty   (a_dirty),
      .a_alt     (a_alt),
      .a_tag     (a_tag),
      .a_data    (a_data),
      .b_valid   (b_valid),
      .b_dirty   (b_dirty),
      .b_alt     (b_alt),
      .b_tag     (b_tag),
      .b_data    (b_data),
      .fill_en   (fill_en),
      .fill_idx  (fill_idx),
      .fill_alt  (fill_rehash),
      .fill_tag  (fill_addr[ADDR_W-1:IDX_W]),
      .fill_data (fill_data),
      .swap_en   (swap_en),
      .upd_en    (upd_en),
      .upd_data  (wdata_q)
   );

   hrc_way_cmp #(.TAG_W(TAG_W)) u_cmp_home (
      .line_valid (a_valid),
      .line_alt   (a_alt),
      .line_tag   (a_tag),
      .req_tag    (req_tag),
      .want_alt   (1'b0),
      .match      (hit_home)
   );

   hrc_way_cmp #(.TAG_W(TAG_W)) u_cmp_alt (
      .line_valid (b_valid),
      .line_alt   (b_alt),
      .line_tag   (b_tag),
      .req_tag    (req_tag),
      .want_alt   (1'b1),
      .match      (hit_alt)
   );

   hrc_probe_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .start    (accept),
      .hit_home (hit_home),
      .st       (st)
   );

   assign swap_en = (st == ST_PROBE2) && hit_alt;
   assign upd_en  = we_q && (((st == ST_PROBE1) && hit_home) || swap_en);

   // latch the outcome of whichever probe decides the request
   always_ff @(posedge clk) begin
      if (rst) begin
         res_hit_q   <= 1'b0;
         res_dirty_q <= 1'b0;
         res_data_q  <= '0;
      end else if (st == ST_PROBE1 && hit_home) begin
         res_hit_q   <= 1'b1;
         res_dirty_q <= we_q | a_dirty;
         res_data_q  <= we_q ? wdata_q : a_data;
      end else if (st == ST_PROBE2) begin
         res_hit_q   <= hit_alt;
         res_dirty_q <= hit_alt && (we_q | b_dirty);
         res_data_q  <= hit_alt ? (we_q ? wdata_q : b_data) : '0;
      end
   end

   assign resp_hit   = (st == ST_RESP) && res_hit_q;
   assign resp_miss  = (st == ST_RESP) && !res_hit_q;
   assign resp_rdata = res_data_q;
   assign resp_dirty = res_dirty_q;

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> busy);

   // R9
   resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({resp_hit, resp_miss}));

   // R9
   resp_single_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_hit || resp_miss) |=> !(resp_hit || resp_miss));

   // R4
   miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
      resp_miss |-> (resp_rdata == '0) && !resp_dirty);

   // R6
   swap_hit_chk: assert property (@(posedge clk) disable iff (rst)
      swap_en |=> resp_hit);

endmodule

// File: tb/tb_hrc_cache.sv
`timescale 1ns/1ps
module tb_hrc_cache;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst;
   logic              req_valid, req_we;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic              busy, resp_hit, resp_miss, resp_dirty;
   logic [DATA_W-1:0] resp_rdata;
   logic              fill_valid, fill_rehash;
   logic [ADDR_W-1:0] fill_addr;
   logic [DATA_W-1:0] fill_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   hrc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .resp_hit(resp_hit), .resp_miss(resp_miss),
      .resp_rdata(resp_rdata), .resp_dirty(resp_dirty),
      .fill_valid(fill_valid), .fill_rehash(fill_rehash),
      .fill_addr(fill_addr), .fill_data(fill_data)
   );

   // op: 0 fill home, 1 fill alternate, 2 read, 3 write
   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] addr;
      logic [31:0] data;
      logic        hit;
      logic [1:0]  lat;
      logic        dirty;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{2'd2, 16'h0003, 32'h00000000, 1'b0, 2'd2, 1'b0, 4'd1},  // R1 empty after reset
      '{2'd0, 16'h0A03, 32'h11111111, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 fill home
      '{2'd2, 16'h0A03, 32'h11111111, 1'b1, 2'd1, 1'b0, 4'd2},  // R2 home hit
      '{2'd2, 16'h0B03, 32'h00000000, 1'b0, 2'd2, 1'b0, 4'd4},  // R4 alias miss
      '{2'd1, 16'h0C05, 32'h22222222, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 fill alternate (slot 13)
      '{2'd2, 16'h0C05, 32'h22222222, 1'b1, 2'd2, 1'b0, 4'd3},  // R3 alternate hit
      '{2'd2, 16'h0C05, 32'h22222222, 1'b1, 2'd1, 1'b0, 4'd6},  // R6 now home
      '{2'd3, 16'h0A03, 32'h33333333, 1'b1, 2'd1, 1'b1, 4'd7},  // R7 write hit
      '{2'd2, 16'h0A03, 32'h33333333, 1'b1, 2'd1, 1'b1, 4'd7},  // R7 dirty kept
      '{2'd0, 16'h0D0D, 32'h55555555, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 fill slot 13 home
      '{2'd2, 16'h0D05, 32'h00000000, 1'b0, 2'd2, 1'b0, 4'd5},  // R5 same tag wrong flag
      '{2'd2, 16'h0D0D, 32'h55555555, 1'b1, 2'd1, 1'b0, 4'd5},  // R5 right flag
      '{2'd3, 16'h0E07, 32'h77777777, 1'b0, 2'd2, 1'b0, 4'd4},  // R4 write miss
      '{2'd2, 16'h0E07, 32'h00000000, 1'b0, 2'd2, 1'b0, 4'd4},  // R4 no allocation
      '{2'd1, 16'h0F01, 32'h88888888, 1'b0, 2'd0, 1'b0, 4'd10}, // R10 fill slot 9 alternate
      '{2'd3, 16'h0F01, 32'h44444444, 1'b1, 2'd2, 1'b1, 4'd7},  // R7 write alternate hit
      '{2'd2, 16'h0F01, 32'h44444444, 1'b1, 2'd1, 1'b1, 4'd6},  // R6 moved and dirty
      '{2'd0, 16'h0106, 32'h66666666, 1'b0, 2'd0, 1'b0, 4'd10}, // R10
      '{2'd1, 16'h0206, 32'h99999999, 1'b0, 2'd0, 1'b0, 4'd10}, // R10
      '{2'd2, 16'h0206, 32'h99999999, 1'b1, 2'd2, 1'b0, 4'd6},  // R6 swap with valid line
      '{2'd2, 16'h0106, 32'h66666666, 1'b1, 2'd2, 1'b0, 4'd6},  // R6 displaced line found
      '{2'd2, 16'h0106, 32'h66666666, 1'b1, 2'd1, 1'b0, 4'd6},  // R6 swapped back
      '{2'd0, 16'h0A03, 32'hAAAAAAAA, 1'b0, 2'd0, 1'b0, 4'd7},  // R7 refill clears dirty
      '{2'd2, 16'h0A03, 32'hAAAAAAAA, 1'b1, 2'd1, 1'b0, 4'd7}   // R7 clean again
   };

   task automatic check(input bit ok, input int rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic do_fill(input logic [15:0] a, input logic [31:0] d, input bit alt);
      @(negedge clk);
      fill_valid = 1'b1; fill_rehash = alt; fill_addr = a; fill_data = d;
      @(negedge clk);
      fill_valid = 1'b0; fill_rehash = 1'b0;
   endtask

   task automatic do_req(input bit we, input logic [15:0] a, input logic [31:0] d,
                         input bit eh, input int el, input logic [31:0] ed,
                         input bit edirty, input int rq);
      int lat = 0;
      bit got_hit = 1'b0;
      logic [31:0] rd = '0;
      bit dty = 1'b0;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if ((resp_hit || resp_miss) && lat == 0) begin
            lat = k; got_hit = resp_hit; rd = resp_rdata; dty = resp_dirty;
         end
      end
      check(got_hit == eh, rq, "hit flag", 32'(got_hit), 32'(eh));
      check(lat == el, rq, "latency", 32'(lat), 32'(el));
      check(rd == ed, rq, "read data", rd, ed);
      check(dty == edirty, rq, "dirty", 32'(dty), 32'(edirty));
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual expired expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seen;
      rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
      fill_valid = 1'b0; fill_rehash = 1'b0; fill_addr = '0; fill_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state at the ports
      check(busy == 1'b0, 1, "busy after reset", 32'(busy), 0);
      check(resp_hit == 1'b0 && resp_miss == 1'b0, 1, "responses after reset",
            32'({resp_hit, resp_miss}), 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].op < 2'd2)
            do_fill(VECS[i].addr, VECS[i].data, VECS[i].op[0]);
         else
            do_req(VECS[i].op[0], VECS[i].addr, VECS[i].data, VECS[i].hit,
                   int'(VECS[i].lat), VECS[i].hit ? VECS[i].data : 32'h0,
                   VECS[i].dirty, int'(VECS[i].rq));
      end

      // R8 busy window: requests and fills offered while busy are dropped
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h0A03;
      @(negedge clk);
      check(busy == 1'b1, 8, "busy after accept", 32'(busy), 1);
      req_addr = 16'h0C05; req_we = 1'b1; req_wdata = 32'hDEADBEEF;
      fill_valid = 1'b1; fill_rehash = 1'b0; fill_addr = 16'h0707; fill_data = 32'h12345678;
      @(negedge clk);
      check(resp_hit == 1'b1, 8, "hit during busy window", 32'(resp_hit), 1);
      check(busy == 1'b1, 8, "busy in response cycle", 32'(busy), 1);
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0; fill_valid = 1'b0;
      seen = 0;
      for (int k = 0; k < 4; k++) begin
         if (resp_hit || resp_miss || busy) seen++;
         @(negedge clk);
      end
      // R9 no extra pulse from the dropped request
      check(seen == 0, 9, "activity after dropped request", 32'(seen), 0);
      // R10 dropped fill left nothing
      do_req(1'b0, 16'h0707, 32'h0, 1'b0, 2, 32'h0, 1'b0, 10);
      // R8 dropped write did not touch the line
      do_req(1'b0, 16'h0C05, 32'h0, 1'b1, 1, 32'h22222222, 1'b0, 8);

      // R1 reset again invalidates all lines
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check(busy == 1'b0, 1, "busy after second reset", 32'(busy), 0);
      do_req(1'b0, 16'h0A03, 32'h0, 1'b0, 2, 32'h0, 1'b0, 1);
      do_req(1'b0, 16'h0C05, 32'h0, 1'b0, 2, 32'h0, 1'b0, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule